// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block sits on the synchronous side of a design. It turns single-word requests into the pin sequences that an external asynchronous static RAM needs. The RAM holds 32K words of 16 bits. Each request carries an address, write data, a byte-enable mask and a read/write flag, and is exchanged through a valid/ready handshake. A read returns its word with a one-cycle valid pulse.

On the memory side the controller drives the address and five active-low controls: chip select, output enable, write enable, and one strobe per byte lane. It also drives the outgoing half of the shared data bus, plus a bus-drive enable, and samples the incoming half. Each timing limit of the RAM is given in picoseconds and converted to whole clock cycles by rounding up. At a 10 ns clock this gives two-cycle read and write phases.

Every write is ended by the byte strobes. This lets a following write, offered while the current one is ending, keep write enable low, so that only the strobes mark out each word. A turnaround cycle separates reads and writes in either order. In that cycle output enable is high and neither side drives the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is applied, and in the first cycle after it, chip select, output enable, write enable and both byte strobes are high, the bus-drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read drives chip select and output enable low and write enable high, with the bus-drive enable low. The byte strobes equal the inverse of the request mask: bit 0 is the lower lane (data bits 7:0) and bit 1 is the upper lane (bits 15:8). Any active strobe is only ever shown with chip select low.
- R3: The read word is sampled on the last read cycle while the strobes are still low. `rsp_valid` then rises for exactly one cycle. A lane whose mask bit is clear returns zero.
- R4: A write drives chip select and write enable low, output enable high and the bus-drive enable high. The strobes follow the inverse mask, so the RAM updates only the enabled lanes. Write enable and output enable are never low together.
- R5: A write ends when all strobes rise while write enable stays low. In that cycle the address and the outgoing data keep their values.
- R6: A write offered during the ending cycle of a previous write is accepted there. Write enable then stays low, and the new address, data and strobes are driven on the next cycle.
- R7: A read following a write, or a write following a read, is preceded by one cycle with write enable, output enable and all strobes high and the bus-drive enable low. Write enable only falls after a cycle in which output enable was high and the bus was not driven.
- R8: `req_ready` goes low on the cycle after a request is accepted. It is high only when idle or in the ending cycle of a write.
- R9: The strobes stay low for `ceil(max(T_RC,T_AA)/CLK)` cycles on a read and `ceil(max(T_WC,T_PWE,T_SD,T_AW)/CLK)` cycles on a write. This is 2 and 2 with the defaults.
- R10: The controller never drives the data bus while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | LANES*LANE_W | Write data |
| req_be | input | LANES | Byte-lane enable mask, bit 0 = lower lane |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | LANES*LANE_W | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_bs_n | output | LANES | Per-lane byte strobes, active low |
| mem_dq_o | output | LANES*LANE_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Bus-drive enable for `mem_dq_o` |
| mem_dq_i | input | LANES*LANE_W | Data sampled from the RAM bus |

## Verification
The hardest case to reach is the back-to-back write. The second request has to arrive in the single cycle in which the first write's strobes have just risen and write enable is still low. Only then does write enable stay low across both words. The directed part of the bench therefore drives requests on exact cycles rather than waiting on the handshake. It offers the second write, and later a read, precisely in that ending cycle, and then checks write enable and the turnaround cycle cycle by cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_WR,
      ST_WEND,
      ST_RD
   } sram_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int at_least_one(input int v);
      return (v < 1) ? 1 : v;
   endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_set,
   input  logic              strobe_en,
   input  logic              strobe_clr,
   input  logic              capture,
   input  logic [LANE_W-1:0] dq_lane_i,
   output logic              bs_n,
   output logic [LANE_W-1:0] rd_byte
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bs_n <= 1'b1;
      end else if (strobe_set) begin
         bs_n <= ~strobe_en;
      end else if (strobe_clr) begin
         bs_n <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_byte <= '0;
      end else if (capture) begin
         rd_byte <= bs_n ? '0 : dq_lane_i;
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter int LANES    = 2,
   parameter int LANE_W   = 8,
   parameter int CLK_PS   = 10000,
   parameter int T_RC_PS  = 12000,
   parameter int T_AA_PS  = 12000,
   parameter int T_WC_PS  = 12000,
   parameter int T_PWE_PS = 9000,
   parameter int T_SD_PS  = 9000,
   parameter int T_AW_PS  = 9000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [LANES*LANE_W-1:0]  req_wdata,
   input  logic [LANES-1:0]         req_be,
   output logic                     rsp_valid,
   output logic [LANES*LANE_W-1:0]  rsp_rdata,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic                     mem_ce_n,
   output logic                     mem_oe_n,
   output logic                     mem_we_n,
   output logic [LANES-1:0]         mem_bs_n,
   output logic [LANES*LANE_W-1:0]  mem_dq_o,
   output logic                     mem_dq_oe,
   input  logic [LANES*LANE_W-1:0]  mem_dq_i
);

   localparam int DATA_W  = LANES * LANE_W;
   localparam int RD_CYC  = at_least_one(ceil_div(max2(T_RC_PS, T_AA_PS), CLK_PS));
   localparam int WR_CYC  = at_least_one(ceil_div(max2(max2(T_WC_PS, T_PWE_PS),
                                                       max2(T_SD_PS, T_AW_PS)), CLK_PS));
   localparam int MAX_CYC = max2(RD_CYC, WR_CYC);
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (LANE_W < 1) begin : g_bad_lane_w
         $error("LANE_W must be at least 1");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
   endgenerate

   sram_state_e state_q, state_d;

   logic              last_rd_q;
   logic              pend_write_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [DATA_W-1:0] pend_wdata_q;
   logic [LANES-1:0]  pend_be_q;

   logic              accept;
   logic              start_rd, start_wr, go_turn, wr_term, rd_done, release_bus;
   logic [ADDR_W-1:0] src_addr;
   logic [DATA_W-1:0] src_wdata;
   logic [LANES-1:0]  src_be;
   logic              cnt_load, cnt_expired;
   logic [CNT_W-1:0]  cnt_load_val;

   assign req_ready = (state_q == ST_IDLE) || (state_q == ST_WEND);
   assign accept    = req_valid && req_ready;

   assign src_addr  = (state_q == ST_TURN) ? pend_addr_q  : req_addr;
   assign src_wdata = (state_q == ST_TURN) ? pend_wdata_q : req_wdata;
   assign src_be    = (state_q == ST_TURN) ? pend_be_q    : req_be;

   always_comb begin
      start_rd    = 1'b0;
      start_wr    = 1'b0;
      go_turn     = 1'b0;
      wr_term     = 1'b0;
      rd_done     = 1'b0;
      release_bus = 1'b0;
      state_d     = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               if (!req_write)     start_rd = 1'b1;
               else if (last_rd_q) go_turn  = 1'b1;
               else                start_wr = 1'b1;
            end
         end
         ST_WEND: begin
            if (accept && req_write) start_wr    = 1'b1;
            else if (accept)         go_turn     = 1'b1;
            else                     release_bus = 1'b1;
         end
         ST_TURN: begin
            if (pend_write_q) start_wr = 1'b1;
            else              start_rd = 1'b1;
         end
         ST_WR:   wr_term = cnt_expired;
         ST_RD:   rd_done = cnt_expired;
         default: state_d = ST_IDLE;
      endcase
      if (start_rd)          state_d = ST_RD;
      else if (start_wr)     state_d = ST_WR;
      else if (go_turn)      state_d = ST_TURN;
      else if (wr_term)      state_d = ST_WEND;
      else if (release_bus)  state_d = ST_IDLE;
      else if (rd_done)      state_d = ST_IDLE;
   end

   assign cnt_load     = start_rd || start_wr;
   assign cnt_load_val = start_rd ? CNT_W'(RD_CYC - 1) : CNT_W'(WR_CYC - 1);

   sram_wait_cnt #(.W(CNT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_load_val),
      .expired  (cnt_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         last_rd_q    <= 1'b0;
         pend_write_q <= 1'b0;
         pend_addr_q  <= '0;
         pend_wdata_q <= '0;
         pend_be_q    <= '0;
         rsp_valid    <= 1'b0;
      end else begin
         state_q   <= state_d;
         rsp_valid <= rd_done;
         if (rd_done)       last_rd_q <= 1'b1;
         else if (start_wr) last_rd_q <= 1'b0;
         if (accept) begin
            pend_write_q <= req_write;
            pend_addr_q  <= req_addr;
            pend_wdata_q <= req_wdata;
            pend_be_q    <= req_be;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_o  <= '0;
         mem_dq_oe <= 1'b0;
      end else if (start_rd) begin
         mem_addr  <= src_addr;
         mem_ce_n  <= 1'b0;
         mem_oe_n  <= 1'b0;
         mem_we_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else if (start_wr) begin
         mem_addr  <= src_addr;
         mem_dq_o  <= src_wdata;
         mem_ce_n  <= 1'b0;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b0;
         mem_dq_oe <= 1'b1;
      end else if (go_turn || release_bus) begin
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else if (rd_done) begin
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
      end
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         sram_byte_lane #(.LANE_W(LANE_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe_set (start_rd || start_wr),
            .strobe_en  (src_be[l]),
            .strobe_clr (go_turn || wr_term || rd_done),
            .capture    (rd_done),
            .dq_lane_i  (mem_dq_i[l*LANE_W +: LANE_W]),
            .bs_n       (mem_bs_n[l]),
            .rd_byte    (rsp_rdata[l*LANE_W +: LANE_W])
         );
      end
   endgenerate

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
   parameter int ADDR_W = 15,
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic                    rsp_valid,
   input logic [ADDR_W-1:0]       mem_addr,
   input logic                    mem_ce_n,
   input logic                    mem_oe_n,
   input logic                    mem_we_n,
   input logic [LANES-1:0]        mem_bs_n,
   input logic [LANES*LANE_W-1:0] mem_dq_o,
   input logic                    mem_dq_oe
);

   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R10

   AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n); // R4

   AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_bs_n != '1) |-> !mem_ce_n); // R2

   AST_WRITE_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n) && ($past(mem_bs_n) != '1) && (mem_bs_n == '1))
      |-> ($stable(mem_addr) && $stable(mem_dq_o))); // R5

   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R3

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R8

   AST_QUIET_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(mem_oe_n) && !$past(mem_dq_oe))); // R7

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .LANES  (LANES),
   .LANE_W (LANE_W)
) u_chk (.*);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 15;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_be = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]    mem_bs_n;
   logic [DW-1:0] mem_dq_o, mem_dq_i;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_async_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   // Small RAM model, indexed by the low six address bits
   logic [DW-1:0] ram [0:63];
   logic          ram_drives;
   logic          fight_seen;

   always_comb begin
      ram_drives = 1'b0;
      for (int l = 0; l < 2; l++) begin
         if (!mem_ce_n && mem_we_n && !mem_oe_n && !mem_bs_n[l]) begin
            mem_dq_i[l*8 +: 8] = ram[mem_addr[5:0]][l*8 +: 8];
            ram_drives = 1'b1;
         end else begin
            mem_dq_i[l*8 +: 8] = 8'hEE;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) ram[i] <= '0;
         fight_seen <= 1'b0;
      end else begin
         if (!mem_ce_n && !mem_we_n)
            for (int l = 0; l < 2; l++)
               if (!mem_bs_n[l]) ram[mem_addr[5:0]][l*8 +: 8] <= mem_dq_o[l*8 +: 8];
         if (mem_dq_oe && ram_drives) fight_seen <= 1'b1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] be);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
   endtask

   task automatic run_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] be, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
      drive(w, a, d, be);
      @(negedge clk);
      req_valid = 1'b0;
      if (!w) begin
         for (int i = 0; i < 20 && !rsp_valid; i++) @(negedge clk);
         chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
         chk({tag, " rdata"}, 32'(rsp_rdata), 32'(exp));
      end
   endtask

   // {write, addr, wdata, be, expected read}
   localparam int VW = 1 + AW + DW + 2 + DW;
   localparam int NV = 11;
   localparam logic [VW-1:0] VEC [0:NV-1] = '{
      {1'b1, 15'h0001, 16'h1234, 2'b11, 16'h0000},
      {1'b1, 15'h0002, 16'hABCD, 2'b11, 16'h0000},
      {1'b0, 15'h0001, 16'h0000, 2'b11, 16'h1234},
      {1'b1, 15'h0001, 16'hFF77, 2'b01, 16'h0000},
      {1'b0, 15'h0001, 16'h0000, 2'b11, 16'h1277},
      {1'b1, 15'h0002, 16'h5500, 2'b10, 16'h0000},
      {1'b0, 15'h0002, 16'h0000, 2'b11, 16'h55CD},
      {1'b0, 15'h0002, 16'h0000, 2'b01, 16'h00CD},
      {1'b0, 15'h0001, 16'h0000, 2'b10, 16'h1200},
      {1'b1, 15'h7FC3, 16'h0F0F, 2'b00, 16'h0000},
      {1'b0, 15'h7FC3, 16'h0000, 2'b11, 16'h0000}
   };

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state while reset is held and just after release
      chk("R1 ready in reset", 32'(req_ready), 32'd1);
      chk("R1 pins in reset", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe}),
          32'b111110);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      chk("R1 pins after reset", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe}),
          32'b111110);

      // Write from idle, then a back-to-back write, then a read in the ending cycle
      drive(1'b1, 15'h0010, 16'hA5C3, 2'b11);
      @(negedge clk); req_valid = 1'b0;
      chk("R4 write pins", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe}),
          32'b010001);
      chk("R4 write addr/data", 32'({mem_addr, mem_dq_o}), 32'({15'h0010, 16'hA5C3}));
      chk("R8 busy in write", 32'(req_ready), 32'd0);
      @(negedge clk);
      chk("R9 write strobe cycle 2", 32'(mem_bs_n), 32'b00);
      @(negedge clk);
      chk("R5 strobes end write", 32'({mem_we_n, mem_bs_n}), 32'b011);
      chk("R5 addr/data held", 32'({mem_addr, mem_dq_o}), 32'({15'h0010, 16'hA5C3}));
      chk("R8 ready in write end", 32'(req_ready), 32'd1);
      drive(1'b1, 15'h0011, 16'h3C5A, 2'b10);
      @(negedge clk); req_valid = 1'b0;
      chk("R6 we stays low", 32'(mem_we_n), 32'd0);
      chk("R6 next word", 32'({mem_addr, mem_dq_o, mem_bs_n}),
          32'({15'h0011, 16'h3C5A, 2'b01}));
      @(negedge clk);
      @(negedge clk);
      chk("R5 second end", 32'({mem_we_n, mem_bs_n}), 32'b011);
      drive(1'b0, 15'h0010, 16'h0000, 2'b11);
      @(negedge clk); req_valid = 1'b0;
      chk("R7 turn after write", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe}),
          32'b111110);
      chk("R8 busy in turn", 32'(req_ready), 32'd0);
      @(negedge clk);
      chk("R2 read pins", 32'({mem_ce_n, mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe}),
          32'b001000);
      @(negedge clk);
      chk("R9 read strobe cycle 2", 32'(mem_bs_n), 32'b00);
      @(negedge clk);
      chk("R3 rsp pulse", 32'(rsp_valid), 32'd1);
      chk("R3 read data", 32'(rsp_rdata), 32'hA5C3);
      chk("R9 read strobes released", 32'(mem_bs_n), 32'b11);
      // Write after read goes through a turnaround cycle
      drive(1'b1, 15'h0012, 16'h7E81, 2'b01);
      @(negedge clk); req_valid = 1'b0;
      chk("R3 rsp one cycle", 32'(rsp_valid), 32'd0);
      chk("R7 turn after read", 32'({mem_oe_n, mem_we_n, mem_bs_n, mem_dq_oe}), 32'b11110);
      @(negedge clk);
      chk("R4 masked write pins", 32'({mem_we_n, mem_bs_n, mem_dq_oe}), 32'b0101);
      repeat (4) @(negedge clk);

      // Read from idle: latency and lane masking
      drive(1'b0, 15'h0011, 16'h0000, 2'b10);
      @(negedge clk); req_valid = 1'b0;
      chk("R2 masked read strobes", 32'(mem_bs_n), 32'b01);
      @(negedge clk);
      chk("R3 no early rsp", 32'(rsp_valid), 32'd0);
      @(negedge clk);
      chk("R3 masked read", 32'({rsp_valid, rsp_rdata}), 32'({1'b1, 16'h3C00}));
      run_op(1'b0, 15'h0012, '0, 2'b11, 16'h0081, "R4 unwritten lane kept");

      // Table walk
      for (int v = 0; v < NV; v++) begin
         run_op(VEC[v][VW-1], VEC[v][VW-2 -: AW], VEC[v][DW+2+DW-1 -: DW],
                VEC[v][DW+1 -: 2], VEC[v][DW-1:0], $sformatf("R4/R3 vector %0d", v));
      end

      repeat (4) @(negedge clk);
      chk("R10 no bus fight", 32'(fight_seen), 32'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule